// File: doc/BRIEF.md
# Calorimeter 2x2 Cluster Builder

The block takes a whole lattice of calorimeter towers in one clock cycle. Each tower carries an electromagnetic energy, a hadronic energy and a fine-grain flag. Its output is one 2x2 cluster for every lattice position. A tower whose combined energy falls below a programmable floor is cleared before any summing takes place. Each surviving tower contributes a saturating 8-bit energy, which is the sum of its two parts. The four towers of a cluster are added into a cluster energy. The block also reports an electron/photon-like shape flag and the OR of the fine-grain flags. Neighbouring clusters overlap by one row or one column, so each tower feeds up to four clusters.

The block is a fixed four-cycle pipeline that accepts a new lattice on every clock. A valid bit travels with the data. The tower floor and the shape shift are sampled together with the lattice they apply to. They can therefore change on any cycle without corrupting results that are already in flight. Positions on the south or east border see the missing towers as zero.

Top module: `cb_cluster_builder`

## Requirements
- R1: A clock edge with `rst_n` low leaves `out_valid`, `tower_lanes`, `cluster_et`, `eg_flag` and `fg_flag` all zero.
- R2: `out_valid` equals the `in_valid` sampled four rising edges earlier, and the data outputs at that time belong to the lattice, floor and shift sampled on that same edge.
- R3: Tower t = r*COLS+c reads its electromagnetic energy from `ecal_et[t*8 +: 8]`, its hadronic energy from `hcal_et[t*8 +: 8]` and its flag from `fine_grain[t]`. Its energy is the sum of the two parts. If that energy is below `tower_thr`, the tower's energy, its two parts and its fine-grain flag all count as zero. A floor of 0 lets every tower pass.
- R4: A tower energy whose sum exceeds 255 is reported as 255 and does not wrap.
- R5: `cluster_et[p*10 +: 10]` is the exact, non-saturated sum of the four tower energies of position p.
- R6: `fg_flag[p]` is the OR of the fine-grain flags of the towers of position p that passed the floor.
- R7: `eg_flag[p]` is 1 exactly when (summed hadronic part << `eg_shift`) <= summed electromagnetic part. Both sums are taken over the surviving towers of position p, and the comparison is done without truncation.
- R8: Position p = r*COLS+c occupies `tower_lanes[(p*4+k)*8 +: 8]`. Lane k=0 holds tower (r,c), k=1 holds (r,c+1), k=2 holds (r+1,c) and k=3 holds (r+1,c+1).
- R9: A lane whose tower lies outside the lattice reads 0 and adds nothing to that position's sums or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Lattice on the inputs is valid |
| ecal_et | input | ROWS*COLS*8 | Electromagnetic energy per tower |
| hcal_et | input | ROWS*COLS*8 | Hadronic energy per tower |
| fine_grain | input | ROWS*COLS | Fine-grain flag per tower |
| tower_thr | input | 8 | Tower energy floor |
| eg_shift | input | 3 | Hadronic weight as a power of two |
| out_valid | output | 1 | Cluster outputs are valid |
| tower_lanes | output | ROWS*COLS*4*8 | Four tower energies per position |
| cluster_et | output | ROWS*COLS*10 | Cluster energy per position |
| eg_flag | output | ROWS*COLS | Shape flag per position |
| fg_flag | output | ROWS*COLS | Fine-grain OR per position |

## Verification
A fault in a tower register appears four cycles after its input as a wrong lane value in up to four overlapping positions. Because the clusters overlap, the same fault also shows in their cluster energies and shape flags. A fault in the valid pipe shows at once as a valid bit out of step with the stimulus. A mis-aligned floor or shift register shows only on cycles where those controls change. The reference model compares every lattice on every cycle while the floor, the shift and the valid pattern change freely, so such a fault is seen on the first affected lattice. Border lanes are checked on their own, so a wrong edge padding is reported against its own requirement.

// File: rtl/cb_pkg.sv
// Shared widths and the per-tower record used by the cluster builder.
package cb_pkg;
    localparam int EW   = 8;              // width of each calorimeter energy part
    localparam int TW   = 8;              // width of a saturated tower energy
    localparam int SHW  = 3;              // width of the shape shift control
    localparam int CW   = TW + 2;         // cluster energy width (four towers)
    localparam int SUMW = EW + 2;         // width of a four-tower part sum
    localparam int CMPW = SUMW + (1 << SHW) - 1; // shifted comparison width

    typedef struct packed {
        logic [EW-1:0] e;   // electromagnetic part after the floor
        logic [EW-1:0] h;   // hadronic part after the floor
        logic [TW-1:0] et;  // saturated tower energy after the floor
        logic          fg;  // fine-grain flag after the floor
    } cb_tower_t;
endpackage

// File: rtl/cb_tower_unit.sv
// Tower stage: adds the two energy parts with saturation and clears the
// whole tower record when the sum is below the floor.
// Assumes: inputs are already registered; one-cycle latency.
module cb_tower_unit
    import cb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] e_in,
    input  logic [EW-1:0] h_in,
    input  logic          fg_in,
    input  logic [TW-1:0] thr,
    output cb_tower_t     q
);
    localparam logic [TW-1:0] TMAX = {TW{1'b1}};

    logic [EW:0]   raw;
    logic [TW-1:0] sat;
    logic          pass;

    // Saturating sum of the two parts and the floor test.
    always_comb begin
        raw  = {1'b0, e_in} + {1'b0, h_in};
        sat  = (raw > (EW+1)'(TMAX)) ? TMAX : TW'(raw);
        pass = (sat >= thr);
    end

    // Register the surviving tower, or an empty one.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (pass)  q <= '{e: e_in, h: h_in, et: sat, fg: fg_in};
        else            q <= '0;
    end

    a_r3_floor_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, e_in} + {1'b0, h_in}) < (EW+1)'(thr)) |=> (q.et == '0 && !q.fg && q.h == '0));

    a_r4_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, e_in} + {1'b0, h_in}) > (EW+1)'(TMAX)) |=> (q.et == TMAX));
endmodule

// File: rtl/cb_cluster_unit.sv
// Cluster stages: gathers four tower records, sums their energies and parts,
// ORs the fine-grain flags, then applies the shifted shape comparison.
// Assumes: border lanes arrive already zeroed; two-cycle latency.
module cb_cluster_unit
    import cb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cb_tower_t       t0,
    input  cb_tower_t       t1,
    input  cb_tower_t       t2,
    input  cb_tower_t       t3,
    input  logic [SHW-1:0]  shift,
    output logic [4*TW-1:0] lanes_o,
    output logic [CW-1:0]   csum_o,
    output logic            eg_o,
    output logic            fg_o
);
    logic [4*TW-1:0] lanes_s;
    logic [CW-1:0]   csum_s;
    logic [SUMW-1:0] esum_s, hsum_s;
    logic            fg_s;
    logic [SHW-1:0]  shift_s;
    logic [CMPW-1:0] h_weighted;

    // Sum stage: lane packing, energy sums and fine-grain OR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_s <= '0; csum_s <= '0; esum_s <= '0;
            hsum_s  <= '0; fg_s   <= 1'b0; shift_s <= '0;
        end else begin
            lanes_s <= {t3.et, t2.et, t1.et, t0.et};
            csum_s  <= CW'(t0.et) + CW'(t1.et) + CW'(t2.et) + CW'(t3.et);
            esum_s  <= SUMW'(t0.e) + SUMW'(t1.e) + SUMW'(t2.e) + SUMW'(t3.e);
            hsum_s  <= SUMW'(t0.h) + SUMW'(t1.h) + SUMW'(t2.h) + SUMW'(t3.h);
            fg_s    <= t0.fg | t1.fg | t2.fg | t3.fg;
            shift_s <= shift;
        end
    end

    // Weighted hadronic sum, widened so the shift cannot drop bits.
    always_comb h_weighted = CMPW'(hsum_s) << shift_s;

    // Output stage: shape comparison and final registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_o <= '0; csum_o <= '0; eg_o <= 1'b0; fg_o <= 1'b0;
        end else begin
            lanes_o <= lanes_s;
            csum_o  <= csum_s;
            eg_o    <= (h_weighted <= CMPW'(esum_s));
            fg_o    <= fg_s;
        end
    end

    a_r6_fg_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        fg_o |-> $past(t0.fg | t1.fg | t2.fg | t3.fg, 2));
endmodule

// File: rtl/cb_cluster_builder.sv
// Top: registers the lattice and controls, runs one tower unit per tower,
// one cluster unit per position with zero padding at the south/east border,
// and carries the valid bit through the four stages.
// Assumes: a new lattice may arrive every cycle; controls travel with data.
module cb_cluster_builder
    import cb_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [ROWS*COLS*EW-1:0] ecal_et,
    input  logic [ROWS*COLS*EW-1:0] hcal_et,
    input  logic [ROWS*COLS-1:0]    fine_grain,
    input  logic [TW-1:0]           tower_thr,
    input  logic [SHW-1:0]          eg_shift,
    output logic                    out_valid,
    output logic [ROWS*COLS*4*TW-1:0] tower_lanes,
    output logic [ROWS*COLS*CW-1:0]   cluster_et,
    output logic [ROWS*COLS-1:0]      eg_flag,
    output logic [ROWS*COLS-1:0]      fg_flag
);
    localparam int NT = ROWS * COLS;

    logic [NT*EW-1:0] e1, h1;
    logic [NT-1:0]    fg1;
    logic [TW-1:0]    thr1;
    logic [SHW-1:0]   sh1, sh2;
    logic             v1, v2, v3;
    cb_tower_t        towers [NT];

    // Input stage: capture lattice and the controls that belong to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e1 <= '0; h1 <= '0; fg1 <= '0; thr1 <= '0; sh1 <= '0; v1 <= 1'b0;
        end else begin
            e1 <= ecal_et; h1 <= hcal_et; fg1 <= fine_grain;
            thr1 <= tower_thr; sh1 <= eg_shift; v1 <= in_valid;
        end
    end

    // Valid and shift alignment through the remaining stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0; v3 <= 1'b0; out_valid <= 1'b0; sh2 <= '0;
        end else begin
            v2 <= v1; v3 <= v2; out_valid <= v3; sh2 <= sh1;
        end
    end

    for (genvar t = 0; t < NT; t++) begin : g_tower
        cb_tower_unit u_tower (
            .clk   (clk),
            .rst_n (rst_n),
            .e_in  (e1[t*EW +: EW]),
            .h_in  (h1[t*EW +: EW]),
            .fg_in (fg1[t]),
            .thr   (thr1),
            .q     (towers[t])
        );
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int P = r * COLS + c;
            cb_tower_t n_e, n_s, n_se;

            if (c + 1 < COLS) begin : g_e
                assign n_e = towers[P+1];
            end else begin : g_e_pad
                assign n_e = '0;
            end
            if (r + 1 < ROWS) begin : g_s
                assign n_s = towers[P+COLS];
            end else begin : g_s_pad
                assign n_s = '0;
            end
            if ((r + 1 < ROWS) && (c + 1 < COLS)) begin : g_se
                assign n_se = towers[P+COLS+1];
            end else begin : g_se_pad
                assign n_se = '0;
            end

            cb_cluster_unit u_cluster (
                .clk     (clk),
                .rst_n   (rst_n),
                .t0      (towers[P]),
                .t1      (n_e),
                .t2      (n_s),
                .t3      (n_se),
                .shift   (sh2),
                .lanes_o (tower_lanes[P*4*TW +: 4*TW]),
                .csum_o  (cluster_et[P*CW +: CW]),
                .eg_o    (eg_flag[P]),
                .fg_o    (fg_flag[P])
            );

            a_r7_empty_is_eg: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && cluster_et[P*CW +: CW] == '0) |-> eg_flag[P]);
        end
    end

    // Cycles since reset, used to bound the latency check.
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));
endmodule

// File: tb/cb_cluster_builder_bench.sv
module cb_cluster_builder_bench;
    localparam int CLK_P = 10;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int NT = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NT*8-1:0] ecal_et = '0, hcal_et = '0;
    logic [NT-1:0]   fine_grain = '0;
    logic [7:0]      tower_thr = '0;
    logic [2:0]      eg_shift = '0;
    logic            out_valid;
    logic [NT*32-1:0] tower_lanes;
    logic [NT*10-1:0] cluster_et;
    logic [NT-1:0]    eg_flag, fg_flag;

    int n_checks = 0;
    int n_fail = 0;

    logic             q_v     [$];
    logic [NT*32-1:0] q_lanes [$];
    logic [NT*10-1:0] q_cs    [$];
    logic [NT-1:0]    q_eg    [$];
    logic [NT-1:0]    q_fg    [$];

    always #(CLK_P/2) clk = ~clk;

    cb_cluster_builder #(.ROWS(ROWS), .COLS(COLS)) u_cb_cluster_builder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ecal_et(ecal_et), .hcal_et(hcal_et), .fine_grain(fine_grain),
        .tower_thr(tower_thr), .eg_shift(eg_shift),
        .out_valid(out_valid), .tower_lanes(tower_lanes),
        .cluster_et(cluster_et), .eg_flag(eg_flag), .fg_flag(fg_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one lattice according to a stimulus mode and queue its expectation.
    task automatic drive_and_predict(input int mode);
        int et[NT], ee[NT], hh[NT], fv[NT];
        logic [NT*32-1:0] xl;
        logic [NT*10-1:0] xc;
        logic [NT-1:0] xe, xf;
        in_valid  = (mode == 5) ? 1'($urandom_range(1, 0)) : 1'b1;
        tower_thr = (mode == 1) ? 8'($urandom_range(200, 60)) :
                    (mode == 3) ? 8'd0 : 8'($urandom_range(40, 0));
        eg_shift  = 3'($urandom_range(7, 0));
        for (int t = 0; t < NT; t++) begin
            int e, h;
            case (mode)
                2:       begin e = 255; h = 255; end
                3:       begin e = 0;   h = 0;   end
                4:       begin e = $urandom_range(255, 120); h = $urandom_range(255, 100); end
                default: begin e = $urandom_range(255, 0);   h = $urandom_range(60, 0);    end
            endcase
            ecal_et[t*8 +: 8] = 8'(e);
            hcal_et[t*8 +: 8] = 8'(h);
            fine_grain[t]     = ($urandom_range(3, 0) == 0);
        end
        for (int t = 0; t < NT; t++) begin
            int s;
            s = ecal_et[t*8 +: 8] + hcal_et[t*8 +: 8];
            if (s > 255) s = 255;
            if (s < tower_thr) begin
                et[t] = 0; ee[t] = 0; hh[t] = 0; fv[t] = 0;
            end else begin
                et[t] = s; ee[t] = ecal_et[t*8 +: 8]; hh[t] = hcal_et[t*8 +: 8];
                fv[t] = fine_grain[t];
            end
        end
        for (int p = 0; p < NT; p++) begin
            int cs, es, hs, f;
            longint hw;
            cs = 0; es = 0; hs = 0; f = 0;
            for (int k = 0; k < 4; k++) begin
                int rr, cc, v;
                rr = p / COLS + k / 2;
                cc = p % COLS + k % 2;
                v = 0;
                if (rr < ROWS && cc < COLS) begin
                    v  = et[rr*COLS+cc];
                    es += ee[rr*COLS+cc];
                    hs += hh[rr*COLS+cc];
                    f  |= fv[rr*COLS+cc];
                end
                cs += v;
                xl[(p*4+k)*8 +: 8] = 8'(v);
            end
            hw = longint'(hs) << eg_shift;
            xc[p*10 +: 10] = 10'(cs);
            xe[p] = (hw <= longint'(es));
            xf[p] = f[0];
        end
        q_v.push_back(in_valid); q_lanes.push_back(xl);
        q_cs.push_back(xc); q_eg.push_back(xe); q_fg.push_back(xf);
    endtask

    // Compare the outputs with the oldest expectation once four are queued.
    task automatic compare_cycle();
        if (q_v.size() < 4) begin
            check("R2 pipeline fill valid", int'(out_valid), 0);
        end else begin
            logic             xv = q_v.pop_front();
            logic [NT*32-1:0] xl = q_lanes.pop_front();
            logic [NT*10-1:0] xc = q_cs.pop_front();
            logic [NT-1:0]    xe = q_eg.pop_front();
            logic [NT-1:0]    xf = q_fg.pop_front();
            check("R2 valid latency", int'(out_valid), int'(xv));
            if (xv) begin
                for (int p = 0; p < NT; p++) begin
                    for (int k = 0; k < 4; k++) begin
                        int rr, cc, xv8;
                        rr = p / COLS + k / 2;
                        cc = p % COLS + k % 2;
                        xv8 = xl[(p*4+k)*8 +: 8];
                        if (rr >= ROWS || cc >= COLS)
                            check("R9 border lane", tower_lanes[(p*4+k)*8 +: 8], xv8);
                        else if (xv8 == 255)
                            check("R4 R8 saturated lane", tower_lanes[(p*4+k)*8 +: 8], xv8);
                        else
                            check("R3 R8 tower lane", tower_lanes[(p*4+k)*8 +: 8], xv8);
                    end
                    check("R5 cluster energy", cluster_et[p*10 +: 10], xc[p*10 +: 10]);
                    check("R6 fine-grain OR", int'(fg_flag[p]), int'(xf[p]));
                    check("R7 shape flag", int'(eg_flag[p]), int'(xe[p]));
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // Reset with junk on the inputs.
        rst_n = 1'b0;
        in_valid = 1'b1;
        ecal_et = '1; hcal_et = '1; fine_grain = '1;
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset lanes", int'(tower_lanes != '0), 0);
        check("R1 reset cluster", int'(cluster_et != '0), 0);
        check("R1 reset eg", int'(eg_flag), 0);
        check("R1 reset fg", int'(fg_flag), 0);
        rst_n = 1'b1;
        for (int ph = 0; ph < 6; ph++) begin
            for (int n = 0; n < 150; n++) begin
                compare_cycle();
                drive_and_predict(ph);
                @(negedge clk);
            end
        end
        for (int n = 0; n < 300; n++) begin
            compare_cycle();
            drive_and_predict($urandom_range(5, 0));
            @(negedge clk);
        end
        for (int n = 0; n < 4; n++) begin
            compare_cycle();
            drive_and_predict(3);
            @(negedge clk);
        end
        finish_run();
    end
endmodule